// File: doc/BRIEF.md
# Bit-Configurable Parallel Port with Pattern Interrupt

This block is one 8-bit parallel port whose pins can each be set as an input or an output when the port runs in bit control mode. A CPU-side write interface loads a 2-bit operating mode, a direction select register, a mask register, a 2-bit match control register, an interrupt enable and the output data. The synchronised pin levels can be read at any time on a dedicated read bus.

In bit control mode, every unmasked input pin takes part in a comparison against a programmed active level. The comparison is combined under either an any-pin (OR) rule or an all-pins (AND) rule. A rising edge of that combined condition raises an interrupt request, which stays up until the CPU acknowledges it. The byte output, byte input and bidirectional modes are only selected here. Their handshake transfers and any interrupt vectoring belong to other logic.

Top module: `bitport_match`

## Requirements
- R1: After reset the port is in byte input mode (mode code 1), the direction register is all ones (all inputs), the mask register is all ones (all masked), the interrupt enable is 0, the output data is 0, `irq` is 0 and `pin_oe` is 0.
- R2: A write with `wr_en` high loads `wr_data` into the register chosen by `wr_sel`, at that clock edge. The select codes are 0 for mode, 1 for direction, 2 for mask, 3 for match control, 4 for output data and 5 for interrupt enable (bit 0). The mode codes are 0 byte output, 1 byte input, 2 bidirectional and 3 bit control.
- R3: `rd_data` equals the value `pin_in` held before two rising clock edges, and it can be read in every mode.
- R4: In bit control mode, `pin_oe[i]` is the inverse of direction bit i (1 means input), and `pin_out` is the output data ANDed with `pin_oe`.
- R5: The direction register has no effect outside bit control mode. In byte output mode `pin_oe` is all ones and `pin_out` is the output data. In byte input and bidirectional modes `pin_oe` and `pin_out` are 0.
- R6: A pin takes part in the match only if its mask bit is 0 and its direction bit is 1. Match control bit 0 selects the active level (1 = high, 0 = low). Match control bit 1 selects the rule (1 = all participating pins active, 0 = any participating pin active).
- R7: When no pin takes part in the match, the condition is false under both rules, whatever the pin levels are.
- R8: In bit control mode with the interrupt enable set, a false-to-true change of the match condition sets `irq` at the third rising edge after the pin change.
- R9: `irq` stays high until `irq_ack` is sampled high, and it is low after that edge. A match condition that simply stays true does not set `irq` again.
- R10: Clearing the interrupt enable, or leaving bit control mode, drops a pending `irq` one edge after the write and blocks new requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Synchronised pin levels |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |
| irq_ack | input | 1 | Acknowledge that clears the request |
| irq | output | 1 | Pattern-match interrupt request |

## Verification
A register write takes effect at the edge that samples it, so output enables and drive values are checked at the falling edge after the write. A pin change shows on `rd_data` after two rising edges, and any interrupt it causes follows at the third. Each swept vector therefore checks `rd_data` and a still-low `irq` after two edges, then checks `irq` against the arithmetically predicted rising edge of the match after the third. Before each vector, an acknowledge pulse clears the previous request, which keeps the vectors independent.

// File: rtl/bitport_pkg.sv
package bitport_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE_OUT = 2'd0,
        MODE_BYTE_IN  = 2'd1,
        MODE_BIDIR    = 2'd2,
        MODE_BIT      = 2'd3
    } port_mode_e;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_MODE = 3'd0;
    localparam logic [SEL_W-1:0] SEL_DIR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MASK = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MCTL = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DOUT = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IE   = 3'd5;

endpackage

// File: rtl/bp_sync.sv
module bp_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/bp_match.sv
module bp_match #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] sample,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] dir,
    input  logic             level_hi,
    input  logic             all_rule,
    output logic             match
);

    logic [WIDTH-1:0] active;
    logic [WIDTH-1:0] at_level;
    logic             any_hit;
    logic             all_hit;

    always_comb begin
        active   = ~mask & dir;
        at_level = level_hi ? sample : ~sample;
        any_hit  = |(at_level & active);
        all_hit  = &(at_level | ~active);
        if (active == '0) begin
            match = 1'b0;
        end else begin
            match = all_rule ? all_hit : any_hit;
        end
    end

endmodule

// File: rtl/bitport_match.sv
module bitport_match
    import bitport_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [WIDTH-1:0]     wr_data,
    output logic [WIDTH-1:0]     rd_data,
    input  logic [WIDTH-1:0]     pin_in,
    output logic [WIDTH-1:0]     pin_out,
    output logic [WIDTH-1:0]     pin_oe,
    input  logic                 irq_ack,
    output logic                 irq
);

    localparam int MCTL_W = 2;

    typedef struct packed {
        port_mode_e              mode;
        logic [WIDTH-1:0]        dir;
        logic [WIDTH-1:0]        mask;
        logic [MCTL_W-1:0]       mctl;
        logic [WIDTH-1:0]        dout;
        logic                    ie;
        logic                    match_q;
        logic                    irq;
    } state_t;

    state_t s_d, s_q;

    logic [WIDTH-1:0] pins_sync;
    logic             match;
    logic             bit_mode;
    logic             armed;
    logic             rise;

    bp_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_DEPTH)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    bp_match #(
        .WIDTH (WIDTH)
    ) i_match (
        .sample   (pins_sync),
        .mask     (s_q.mask),
        .dir      (s_q.dir),
        .level_hi (s_q.mctl[0]),
        .all_rule (s_q.mctl[1]),
        .match    (match)
    );

    always_comb begin
        s_d      = s_q;
        bit_mode = (s_q.mode == MODE_BIT);
        armed    = bit_mode && s_q.ie;
        rise     = match && !s_q.match_q;

        if (wr_en) begin
            case (wr_sel)
                SEL_MODE: s_d.mode = port_mode_e'(wr_data[1:0]);
                SEL_DIR:  s_d.dir  = wr_data;
                SEL_MASK: s_d.mask = wr_data;
                SEL_MCTL: s_d.mctl = wr_data[MCTL_W-1:0];
                SEL_DOUT: s_d.dout = wr_data;
                SEL_IE:   s_d.ie   = wr_data[0];
                default:  ;
            endcase
        end

        s_d.match_q = match;

        if (!armed) begin
            s_d.irq = 1'b0;
        end else if (rise) begin
            s_d.irq = 1'b1;
        end else if (irq_ack) begin
            s_d.irq = 1'b0;
        end

        case (s_q.mode)
            MODE_BYTE_OUT: pin_oe = '1;
            MODE_BIT:      pin_oe = ~s_q.dir;
            default:       pin_oe = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode    <= MODE_BYTE_IN;
            s_q.dir     <= '1;
            s_q.mask    <= '1;
            s_q.mctl    <= '0;
            s_q.dout    <= '0;
            s_q.ie      <= 1'b0;
            s_q.match_q <= 1'b0;
            s_q.irq     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pin_out = s_q.dout & pin_oe;
    assign rd_data = pins_sync;
    assign irq     = s_q.irq;

    // R7
    all_masked_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask == '1) |-> !match);

    // R8
    irq_needs_arming_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(s_q.mode == MODE_BIT && s_q.ie));

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack && s_q.ie && s_q.mode == MODE_BIT && !wr_en) |=> irq);

    // R5
    byte_in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_BYTE_IN) |-> (pin_oe == '0 && pin_out == '0));

    // R10
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ie || s_q.mode != MODE_BIT) |=> !irq);

endmodule

// File: tb/test_bitport_match.sv
module test_bitport_match;
    import bitport_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       irq_ack = 1'b0;
    logic       irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    bitport_match i_bitport_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq_ack (irq_ack),
        .irq     (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit model_match(input logic [7:0] v, input logic [7:0] m,
                                       input logic [7:0] d, input logic [1:0] c);
        logic [7:0] act;
        logic [7:0] lv;
        act = ~m & d;
        lv  = c[0] ? v : ~v;
        if (act == 8'h00) return 1'b0;
        if (c[1]) return ((lv & act) == act);
        return ((lv & act) != 8'h00);
    endfunction

    logic [7:0] cfg_mask [5] = '{8'h00, 8'h5A, 8'hF0, 8'h00, 8'hFF};
    logic [7:0] cfg_dir  [5] = '{8'hFF, 8'hFF, 8'h0F, 8'h3C, 8'hFF};

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 rd_data", rd_data, 8'h00);
        // R1: bit mode with reset dir/mask: no drive, no interrupt
        wr(SEL_MODE, 8'd3);
        wr(SEL_IE, 8'd1);
        check("R1 dir all inputs", pin_oe, 8'h00);
        pin_in = 8'hFF; tick(4);
        pin_in = 8'h00; tick(4);
        check("R1 mask all set", {7'd0, irq}, 8'h00);

        // R2/R4 direction sweep in bit mode
        wr(SEL_DOUT, 8'hA5);
        for (int d = 0; d < 256; d++) begin
            wr(SEL_DIR, 8'(d));
            check("R4 pin_oe", pin_oe, ~8'(d));
            check("R4 pin_out", pin_out, 8'hA5 & ~8'(d));
        end

        // R5 other modes ignore direction
        wr(SEL_DIR, 8'h00);
        wr(SEL_MODE, 8'd1);
        check("R5 byte in oe", pin_oe, 8'h00);
        check("R5 byte in out", pin_out, 8'h00);
        wr(SEL_MODE, 8'd0);
        check("R5 byte out oe", pin_oe, 8'hFF);
        check("R5 byte out data", pin_out, 8'hA5);
        wr(SEL_DIR, 8'hF0);
        check("R5 byte out dir ignored", pin_oe, 8'hFF);
        wr(SEL_MODE, 8'd2);
        check("R5 bidir oe", pin_oe, 8'h00);
        check("R5 bidir out", pin_out, 8'h00);
        wr(SEL_MODE, 8'd3);
        check("R2 bit mode oe", pin_oe, 8'h0F);
        check("R2 bit mode out", pin_out, 8'h05);

        // R3/R6/R7/R8 match sweep
        for (int k = 0; k < 5; k++) begin
            for (int c = 0; c < 4; c++) begin
                bit prev;
                wr(SEL_MASK, cfg_mask[k]);
                wr(SEL_DIR, cfg_dir[k]);
                wr(SEL_MCTL, 8'(c));
                pin_in = 8'h00;
                tick(4);
                prev = model_match(8'h00, cfg_mask[k], cfg_dir[k], 2'(c));
                for (int v = 0; v < 256; v++) begin
                    bit now;
                    ack_pulse();
                    pin_in = 8'(v);
                    tick(2);
                    check("R3 rd_data", rd_data, 8'(v));
                    check("R8 irq early", {7'd0, irq}, 8'h00);
                    tick(1);
                    now = model_match(8'(v), cfg_mask[k], cfg_dir[k], 2'(c));
                    if (cfg_mask[k] == 8'hFF)
                        check("R7 irq", {7'd0, irq}, {7'd0, now && !prev});
                    else
                        check("R6 irq", {7'd0, irq}, {7'd0, now && !prev});
                    prev = now;
                end
            end
        end

        // R9 hold and no retrigger
        wr(SEL_MASK, 8'h00); wr(SEL_DIR, 8'hFF); wr(SEL_MCTL, 8'd1);
        pin_in = 8'h00; tick(4); ack_pulse();
        pin_in = 8'h01; tick(3);
        check("R9 set", {7'd0, irq}, 8'h01);
        pin_in = 8'h00; tick(4);
        check("R9 held", {7'd0, irq}, 8'h01);
        ack_pulse();
        check("R9 ack clears", {7'd0, irq}, 8'h00);
        pin_in = 8'h01; tick(3);
        check("R9 set again", {7'd0, irq}, 8'h01);
        ack_pulse();
        tick(5);
        check("R9 no retrigger", {7'd0, irq}, 8'h00);

        // R10 disable clears and blocks
        pin_in = 8'h00; tick(4);
        pin_in = 8'h01; tick(3);
        check("R10 pending", {7'd0, irq}, 8'h01);
        wr(SEL_IE, 8'd0);
        tick(1);
        check("R10 ie off clears", {7'd0, irq}, 8'h00);
        pin_in = 8'h00; tick(4);
        pin_in = 8'h01; tick(4);
        check("R10 ie off blocks", {7'd0, irq}, 8'h00);
        wr(SEL_IE, 8'd1);
        pin_in = 8'h00; tick(4);
        pin_in = 8'h01; tick(3);
        check("R10 pending again", {7'd0, irq}, 8'h01);
        wr(SEL_MODE, 8'd1);
        tick(1);
        check("R10 mode change clears", {7'd0, irq}, 8'h00);
        pin_in = 8'h00; tick(4);
        pin_in = 8'h01; tick(4);
        check("R10 byte mode blocks", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule